// File: doc/BRIEF.md
# Iterative ChaCha Keystream Block Engine

This block produces 512-bit ChaCha keystream blocks and returns each one XORed with a 512-bit data block. A single quarterround datapath is time-shared across the whole computation. It handles one quarterround per clock, so a double round takes eight cycles. The block works with either a 128-bit or a 256-bit key. The number of rounds is chosen at run time. The engine also keeps its own 64-bit block counter, which advances after every block it delivers.

Software starts a stream with an init strobe. Init loads the key, the key length, the nonce, the round count and the counter start value, and it also computes the first block. Each later next strobe reuses the stored key material with the advanced counter and a new data block. While a block is in flight the engine shows itself busy. When a block is done, the finished result is held steady and marked valid until another strobe is accepted.

The controller has four named states:
- S_IDLE: ready, waiting for a strobe.
- S_SETUP: loads the working state from the captured inputs.
- S_ROUND: applies one quarterround per cycle.
- S_FINISH: forms and registers the result.

The transitions are:
- IDLE→SETUP: on an accepted strobe.
- SETUP→ROUND: always.
- ROUND→FINISH: after the last quarterround.
- FINISH→IDLE: always.

Top module: `chacha_core`

## Requirements
- R1: After reset, ready_o is 1, valid_o is 0 and result_o is all zero.
- R2: With key256_i=1 the state words 0..3 are the constant "expand 32-byte k" and words 4..11 are key_i words 0..7, where key word k is key_i[32k+31:32k]. With key256_i=0 the constant is "expand 16-byte k", and key_i[127:0] fills both words 4..7 and words 8..11. key_i[255:128] is then ignored.
- R3: The round count is taken from rounds_i on init. Bit 0 is ignored. If the remaining even value is 0 or above 32, the default of 8 rounds is used.
- R4: Even-numbered rounds (counting from 0) apply the standard quarterround to the columns (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). Odd-numbered rounds apply it to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14). For 20 rounds, an all-zero key, an all-zero nonce and counter 0, result word 0 is 0xade0b876 and result word 1 is 0x903df1a0.
- R5: result_o word i (bits 32i+31:32i) equals (final state word i + initial state word i mod 2^32) XOR the data_i word i captured at the accepted strobe.
- R6: init loads the counter from ctr_i. Words 12 and 13 hold the counter, low half first. The counter rises by one, wrapping at 2^64, after each delivered block, so successive next strobes use n+1, n+2 and so on.
- R7: Words 14 and 15 hold nonce_i[31:0] and nonce_i[63:32], captured on init.
- R8: From the accepting clock edge, ready_o is 0. ready_o and valid_o both rise on the (4·rounds+2)-th rising edge after that edge.
- R9: valid_o stays 1 and result_o stays unchanged until the next accepted strobe. An accepted strobe clears valid_o at its edge.
- R10: An init or next strobe that arrives while ready_o is 0 is ignored. The running block, the counter and the stored key material are unchanged by it.
- R11: If init_i and next_i are high together while ready, the strobe acts as init.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load key material and counter, then compute a block |
| next_i | input | 1 | Compute the next block with the stored key material |
| key_i | input | 256 | Key; only bits 127:0 are used for 128-bit keys |
| key256_i | input | 1 | 1 selects a 256-bit key, 0 selects a 128-bit key |
| nonce_i | input | 64 | Nonce, captured on init |
| ctr_i | input | 64 | Counter start value, captured on init |
| rounds_i | input | 6 | Requested round count, captured on init |
| data_i | input | 512 | Data block XORed with the keystream, captured on a strobe |
| ready_o | output | 1 | Engine idle and able to accept a strobe |
| valid_o | output | 1 | result_o holds a finished block |
| result_o | output | 512 | Keystream XOR data, word i at bits 32i+31:32i |

## Verification
Several handshake rules are checked by assertions on every cycle:
- An accepted strobe drops both ready and valid on the next cycle.
- valid and result stay frozen until the next accepted strobe.
- valid only rises together with ready.
- A busy period never exceeds the longest legal latency.
- result stays zero until the first block is delivered.

Other behaviours need the bench's scenarios and its independent reference model:
- the cryptographic content of each block;
- counter loading, stepping and carry across the 32-bit boundary;
- the effect of the key-length choice;
- how the round count is decoded;
- the exact latency;
- the fact that strobes during a busy period leave the counter untouched.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] state_t;

    // "expand 32-byte k" and "expand 16-byte k", index 0 is state word 0
    localparam logic [3:0][31:0] CONST_256 =
        {32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
    localparam logic [3:0][31:0] CONST_128 =
        {32'h6b206574, 32'h79622d36, 32'h3120646e, 32'h61707865};

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SETUP  = 2'd1,
        S_ROUND  = 2'd2,
        S_FINISH = 2'd3
    } fsm_t;

    // Word indices for lane col; diag selects diagonal instead of column
    function automatic logic [3:0] lane_a(logic [1:0] col);
        return {2'b00, col};
    endfunction

    function automatic logic [3:0] lane_b(logic [1:0] col, logic diag);
        return {2'b01, (diag ? col + 2'd1 : col)};
    endfunction

    function automatic logic [3:0] lane_c(logic [1:0] col, logic diag);
        return {2'b10, (diag ? col + 2'd2 : col)};
    endfunction

    function automatic logic [3:0] lane_d(logic [1:0] col, logic diag);
        return {2'b11, (diag ? col + 2'd3 : col)};
    endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
    import chacha_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    output word_t a_o,
    output word_t b_o,
    output word_t c_o,
    output word_t d_o
);

    function automatic word_t rotl(word_t x, int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    word_t a1, b1, c1, d1;
    word_t a2, b2, c2, d2;

    always_comb begin
        a1 = a_i + b_i;
        d1 = rotl(d_i ^ a1, 16);
        c1 = c_i + d1;
        b1 = rotl(b_i ^ c1, 12);
        a2 = a1 + b1;
        d2 = rotl(d1 ^ a2, 8);
        c2 = c1 + d2;
        b2 = rotl(b1 ^ c2, 7);
    end

    assign a_o = a2;
    assign b_o = b2;
    assign c_o = c2;
    assign d_o = d2;

endmodule

// File: rtl/chacha_init_state.sv
module chacha_init_state
    import chacha_pkg::*;
(
    input  logic [255:0] key_i,
    input  logic         key256_i,
    input  logic [63:0]  nonce_i,
    input  logic [63:0]  ctr_i,
    output state_t       st_o
);

    always_comb begin
        st_o = '0;
        for (int i = 0; i < 4; i++) begin
            st_o[i]     = key256_i ? CONST_256[i] : CONST_128[i];
            st_o[4 + i] = key_i[32*i +: 32];
            st_o[8 + i] = key256_i ? key_i[128 + 32*i +: 32] : key_i[32*i +: 32];
        end
        st_o[12] = ctr_i[31:0];
        st_o[13] = ctr_i[63:32];
        st_o[14] = nonce_i[31:0];
        st_o[15] = nonce_i[63:32];
    end

endmodule

// File: rtl/chacha_ctrl.sv
module chacha_ctrl
    import chacha_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STEP_W-1:0] total_steps_i,
    output logic              ready_o,
    output logic              valid_o,
    output logic              accept_o,
    output logic              load_o,
    output logic              qr_en_o,
    output logic              finish_o,
    output logic [1:0]        qr_col_o,
    output logic              diag_o
);

    fsm_t              state_q, state_d;
    logic [STEP_W-1:0] step_q;
    logic              last_step;
    logic              valid_q;

    assign last_step = (step_q == total_steps_i - STEP_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SETUP;
            S_SETUP:  state_d = S_ROUND;
            S_ROUND:  if (last_step) state_d = S_FINISH;
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready_o  = 1'b0;
        load_o   = 1'b0;
        qr_en_o  = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            S_IDLE:   ready_o  = 1'b1;
            S_SETUP:  load_o   = 1'b1;
            S_ROUND:  qr_en_o  = 1'b1;
            S_FINISH: finish_o = 1'b1;
        endcase
    end

    assign accept_o = ready_o && start_i;
    assign qr_col_o = step_q[1:0];
    assign diag_o   = step_q[2];
    assign valid_o  = valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       step_q <= '0;
        else if (load_o)  step_q <= '0;
        else if (qr_en_o) step_q <= step_q + STEP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        valid_q <= 1'b0;
        else if (accept_o) valid_q <= 1'b0;
        else if (finish_o) valid_q <= 1'b1;
    end

endmodule

// File: rtl/chacha_core.sv
module chacha_core
    import chacha_pkg::*;
#(
    parameter int DEFAULT_ROUNDS = 8,
    parameter int MAX_ROUNDS     = 32,
    parameter int ROUND_W        = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               next_i,
    input  logic [255:0]       key_i,
    input  logic               key256_i,
    input  logic [63:0]        nonce_i,
    input  logic [63:0]        ctr_i,
    input  logic [ROUND_W-1:0] rounds_i,
    input  logic [511:0]       data_i,
    output logic               ready_o,
    output logic               valid_o,
    output logic [511:0]       result_o
);

    localparam int STEP_W = ROUND_W + 2;
    localparam logic [ROUND_W-1:0] MAX_R = ROUND_W'(MAX_ROUNDS);
    localparam logic [ROUND_W-1:0] DEF_R = ROUND_W'(DEFAULT_ROUNDS);

    // captured configuration and data
    logic [255:0]       key_q;
    logic               key256_q;
    logic [63:0]        nonce_q;
    logic [63:0]        ctr_q;
    logic [ROUND_W-1:0] rounds_q;
    state_t             data_q;
    state_t             result_q;
    state_t             work_q;
    state_t             init_s;

    // control strobes
    logic       accept, load, qr_en, finish;
    logic [1:0] qr_col;
    logic       diag;

    // round-count decode
    logic [ROUND_W-1:0] rnd_even, rnd_eff;
    assign rnd_even = {rounds_i[ROUND_W-1:1], 1'b0};
    assign rnd_eff  = (rnd_even == '0 || rnd_even > MAX_R) ? DEF_R : rnd_even;

    chacha_ctrl #(.STEP_W(STEP_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (init_i | next_i),
        .total_steps_i ({rounds_q, 2'b00}),
        .ready_o       (ready_o),
        .valid_o       (valid_o),
        .accept_o      (accept),
        .load_o        (load),
        .qr_en_o       (qr_en),
        .finish_o      (finish),
        .qr_col_o      (qr_col),
        .diag_o        (diag)
    );

    chacha_init_state u_init (
        .key_i    (key_q),
        .key256_i (key256_q),
        .nonce_i  (nonce_q),
        .ctr_i    (ctr_q),
        .st_o     (init_s)
    );

    // lane selection for the shared quarterround
    logic [3:0] ia, ib, ic, id;
    assign ia = lane_a(qr_col);
    assign ib = lane_b(qr_col, diag);
    assign ic = lane_c(qr_col, diag);
    assign id = lane_d(qr_col, diag);

    word_t qa, qb, qc, qd;

    chacha_qr u_qr (
        .a_i (work_q[ia]),
        .b_i (work_q[ib]),
        .c_i (work_q[ic]),
        .d_i (work_q[id]),
        .a_o (qa),
        .b_o (qb),
        .c_o (qc),
        .d_o (qd)
    );

    always_ff @(posedge clk) begin
        if (load) begin
            work_q <= init_s;
        end else if (qr_en) begin
            work_q[ia] <= qa;
            work_q[ib] <= qb;
            work_q[ic] <= qc;
            work_q[id] <= qd;
        end
    end

    // feed-forward addition and data mix, one lane per word
    wire state_t mix;
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mix
        assign mix[w] = (work_q[w] + init_s[w]) ^ data_q[w];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q    <= '0;
            key256_q <= 1'b0;
            nonce_q  <= '0;
            ctr_q    <= '0;
            rounds_q <= DEF_R;
            data_q   <= '0;
            result_q <= '0;
        end else begin
            if (accept && init_i) begin
                key_q    <= key_i;
                key256_q <= key256_i;
                nonce_q  <= nonce_i;
                ctr_q    <= ctr_i;
                rounds_q <= rnd_eff;
            end else if (finish) begin
                ctr_q <= ctr_q + 64'd1;
            end
            if (accept) data_q <= data_i;
            if (finish) result_q <= mix;
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/chacha_core_chk.sv
module chacha_core_chk #(
    parameter int MAX_ROUNDS = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         init_i,
    input logic         next_i,
    input logic         ready_o,
    input logic         valid_o,
    input logic [511:0] result_o
);

    localparam int BUSY_MAX = 4 * MAX_ROUNDS + 2;

    logic [9:0] busy_cnt;
    logic       seen_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt   <= '0;
            seen_valid <= 1'b0;
        end else begin
            busy_cnt <= ready_o ? 10'd0 : busy_cnt + 10'd1;
            if (valid_o) seen_valid <= 1'b1;
        end
    end

    // R8
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && (init_i || next_i) |=> !ready_o && !valid_o);

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !(ready_o && (init_i || next_i)) |=> valid_o && $stable(result_o));

    // R8
    valid_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ready_o);

    // R8
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 10'(BUSY_MAX));

    // R1
    reset_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_valid && !valid_o |-> result_o == '0);

endmodule

bind chacha_core chacha_core_chk #(.MAX_ROUNDS(MAX_ROUNDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_i   (init_i),
    .next_i   (next_i),
    .ready_o  (ready_o),
    .valid_o  (valid_o),
    .result_o (result_o)
);

// File: tb/tb_chacha_core.sv
`timescale 1ns/1ps
module tb_chacha_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         init_i = 1'b0;
    logic         next_i = 1'b0;
    logic [255:0] key_i = '0;
    logic         key256_i = 1'b1;
    logic [63:0]  nonce_i = '0;
    logic [63:0]  ctr_i = '0;
    logic [5:0]   rounds_i = 6'd8;
    logic [511:0] data_i = '0;
    logic         ready_o, valid_o;
    logic [511:0] result_o;

    always #4 clk = ~clk;

    chacha_core dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
        .key_i(key_i), .key256_i(key256_i), .nonce_i(nonce_i), .ctr_i(ctr_i),
        .rounds_i(rounds_i), .data_i(data_i),
        .ready_o(ready_o), .valid_o(valid_o), .result_o(result_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference state of the stream
    logic [255:0] m_key;
    logic         m_k256;
    logic [63:0]  m_nonce;
    logic [63:0]  m_ctr;
    int           m_rounds;

    logic [511:0] exp_q[$];
    string        tag_q[$];
    logic         valid_prev = 1'b0;

    task automatic chk(string req, logic [511:0] act, logic [511:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rotl(logic [31:0] x, int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [127:0] qrf(logic [31:0] a, logic [31:0] b,
                                         logic [31:0] c, logic [31:0] d);
        a = a + b; d = rotl(d ^ a, 16);
        c = c + d; b = rotl(b ^ c, 12);
        a = a + b; d = rotl(d ^ a, 8);
        c = c + d; b = rotl(b ^ c, 7);
        return {a, b, c, d};
    endfunction

    function automatic int eff_rounds(logic [5:0] r);
        int e;
        e = int'(r) & 62;
        return (e == 0 || e > 32) ? 8 : e;
    endfunction

    function automatic logic [511:0] ref_block(logic [255:0] k, logic k256,
                                               logic [63:0] n, logic [63:0] c, int r);
        logic [31:0]  s [16];
        logic [31:0]  x [16];
        logic [511:0] res;
        if (k256) begin
            s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
            for (int i = 0; i < 8; i++) s[4 + i] = k[32*i +: 32];
        end else begin
            s[0] = 32'h61707865; s[1] = 32'h3120646e; s[2] = 32'h79622d36; s[3] = 32'h6b206574;
            for (int i = 0; i < 4; i++) begin
                s[4 + i] = k[32*i +: 32];
                s[8 + i] = k[32*i +: 32];
            end
        end
        s[12] = c[31:0]; s[13] = c[63:32]; s[14] = n[31:0]; s[15] = n[63:32];
        x = s;
        for (int rr = 0; rr < r; rr += 2) begin
            {x[0], x[4], x[8],  x[12]} = qrf(x[0], x[4], x[8],  x[12]);
            {x[1], x[5], x[9],  x[13]} = qrf(x[1], x[5], x[9],  x[13]);
            {x[2], x[6], x[10], x[14]} = qrf(x[2], x[6], x[10], x[14]);
            {x[3], x[7], x[11], x[15]} = qrf(x[3], x[7], x[11], x[15]);
            {x[0], x[5], x[10], x[15]} = qrf(x[0], x[5], x[10], x[15]);
            {x[1], x[6], x[11], x[12]} = qrf(x[1], x[6], x[11], x[12]);
            {x[2], x[7], x[8],  x[13]} = qrf(x[2], x[7], x[8],  x[13]);
            {x[3], x[4], x[9],  x[14]} = qrf(x[3], x[4], x[9],  x[14]);
        end
        for (int i = 0; i < 16; i++) res[32*i +: 32] = x[i] + s[i];
        return res;
    endfunction

    // monitor: compares each new result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_o && !valid_prev) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected block", result_o, '0);
            end else begin
                chk(tag_q.pop_front(), result_o, exp_q.pop_front());
            end
        end
        valid_prev = valid_o;
    end

    // drive one strobe, wait for the block, check latency
    task automatic run_block(bit do_init, bit do_next, logic [511:0] d,
                             string tag, bit poke_busy);
        int cnt;
        @(negedge clk);
        init_i = do_init;
        next_i = do_next;
        data_i = d;
        exp_q.push_back(ref_block(m_key, m_k256, m_nonce, m_ctr, m_rounds) ^ d);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        init_i = 1'b0;
        next_i = 1'b0;
        cnt = 0;
        while (!valid_o) begin
            if (cnt == 1) chk("R8 ready low while busy", {511'd0, ready_o}, 512'd0);
            if (poke_busy && (cnt == 3 || cnt == 9)) begin
                // R10: strobes while busy must be ignored
                init_i = 1'b1;
                next_i = (cnt == 9);
                ctr_i = 64'hDEAD_BEEF_0000_0000;
                key_i = ~m_key;
                rounds_i = 6'd20;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
            init_i = 1'b0;
            next_i = 1'b0;
        end
        chk("R8 latency", 512'(cnt), 512'(4 * m_rounds + 2));
        chk("R8 ready with valid", {511'd0, ready_o}, 512'd1);
        m_ctr = m_ctr + 64'd1;
    endtask

    task automatic start_stream(logic [255:0] k, logic k256, logic [63:0] n,
                                logic [63:0] c, logic [5:0] r, logic [511:0] d,
                                string tag);
        key_i = k; key256_i = k256; nonce_i = n; ctr_i = c; rounds_i = r;
        m_key = k; m_k256 = k256; m_nonce = n; m_ctr = c; m_rounds = eff_rounds(r);
        run_block(1'b1, 1'b0, d, tag, 1'b0);
    endtask

    localparam logic [255:0] KEY_A = 256'h1f1e1d1c_1b1a1918_17161514_13121110_0f0e0d0c_0b0a0908_07060504_03020100;
    localparam logic [255:0] KEY_B = 256'hc3a5_9e11_7f02_44d8_0badf00d_1234_5678_9abc_def0_cafe_babe_5a5a_a5a5_0f0f_f0f0;

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [511:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", {511'd0, ready_o}, 512'd1);
        chk("R1 valid", {511'd0, valid_o}, 512'd0);
        chk("R1 result", result_o, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 known all-zero vector, 20 rounds, 256-bit key
        start_stream('0, 1'b1, '0, '0, 6'd20, '0, "R4 zero vector");
        chk("R4 word0", 512'(result_o[31:0]), 512'(32'hade0b876));
        chk("R4 word1", 512'(result_o[63:32]), 512'(32'h903df1a0));

        // R2 R5 R6 R7: 256-bit key, 8 rounds, then successive next strobes
        start_stream(KEY_A, 1'b1, 64'h4a000000_09000000, 64'h1, 6'd8,
                     {16{32'h0123_4567}}, "R5 R7 init 256 r8");
        run_block(1'b0, 1'b1, {16{32'h89ab_cdef}}, "R6 next n+1", 1'b0);
        run_block(1'b0, 1'b1, {8{64'hffff_0000_5555_aaaa}}, "R10 busy strobes", 1'b1);
        run_block(1'b0, 1'b1, '0, "R10 counter after busy strobes", 1'b0);

        // R9 hold: valid and result stay while no strobe arrives
        held = result_o;
        repeat (6) @(negedge clk);
        chk("R9 valid held", {511'd0, valid_o}, 512'd1);
        chk("R9 result held", result_o, held);

        // R2: 128-bit key with upper half non-zero (must be ignored)
        start_stream(KEY_B, 1'b0, 64'h0706050403020100, 64'h0, 6'd12, '0, "R2 128-bit r12");
        run_block(1'b0, 1'b1, {16{32'h5a5a_a5a5}}, "R2 128-bit next", 1'b0);
        start_stream(KEY_B, 1'b0, 64'h1, 64'h77, 6'd20, '0, "R2 128-bit r20");
        start_stream(KEY_B, 1'b1, 64'h1, 64'h77, 6'd12, '0, "R2 256-bit r12");
        start_stream(KEY_A, 1'b1, 64'h2, 64'h3, 6'd20, {16{32'hf00d_f00d}}, "R4 256-bit r20");

        // R3 round-count decode
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd2,  '0, "R3 two rounds");
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd32, '0, "R3 32 rounds");
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd33, '0, "R3 odd 33 -> 32");
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd3,  '0, "R3 odd 3 -> 2");
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd0,  '0, "R3 zero -> default");
        start_stream(KEY_A, 1'b1, 64'h5, 64'h9, 6'd40, '0, "R3 over max -> default");

        // R6 counter carry into the high word and 64-bit wrap
        start_stream(KEY_A, 1'b1, 64'h6, 64'h0000_0000_ffff_ffff, 6'd8, '0, "R6 low word max");
        run_block(1'b0, 1'b1, '0, "R6 carry to high word", 1'b0);
        start_stream(KEY_A, 1'b1, 64'h6, 64'hffff_ffff_ffff_ffff, 6'd8, '0, "R6 all ones");
        run_block(1'b0, 1'b1, '0, "R6 wrap to zero", 1'b0);

        // R11 init and next together act as init
        key_i = KEY_B; key256_i = 1'b1; nonce_i = 64'h99; ctr_i = 64'h1234; rounds_i = 6'd12;
        m_key = KEY_B; m_k256 = 1'b1; m_nonce = 64'h99; m_ctr = 64'h1234; m_rounds = 12;
        run_block(1'b1, 1'b1, {16{32'h3c3c_c3c3}}, "R11 init wins", 1'b0);

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", 512'(exp_q.size()), 512'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule